// File: doc/BRIEF.md
# Self-Clocked Serial Register Write Port

This block is the write side of a converter-style peripheral's serial port. The peripheral, not the host, produces the bit clock. The host starts a write by pulling an active-low frame strobe low. The block then drives a serial clock out of its own, derived from the system clock, and samples one fixed-length word from the host's data line, most significant bit first, on each rising edge of that clock.

After the last falling edge, the block releases the clock line, which idles high through a pull-up. It then copies the assembled word into one of two parallel registers: a control register or a calibration register. The level of an address-select input, captured when the strobe falls, picks the destination.

If the strobe returns high before the last bit has been sampled, the transfer is abandoned and both registers keep their contents. Strobe, data and select are treated as synchronous to the system clock. A host normally changes its data after each falling edge of the generated clock.

Top module: `selfclk_wr_port`

## Requirements
- R1: During and after reset, and until a transfer starts, `sclk_oe` is 0, `sclk_out` is 1, `wr_done` is 0, `ctrl_reg` equals `CTRL_INIT` and `cal_reg` equals `CAL_INIT` (both 0 by default).
- R2: If `frame_n` is sampled high at one clock edge and low at the next, then after that second edge (E0) `sclk_oe` is 1 and `sclk_out` is 0.
- R3: While enabled, `sclk_out` repeats a low phase of `CLK_DIV/2` system cycles followed by a high phase of `CLK_DIV/2` cycles, starting with the low phase at E0.
- R4: Bit k of a transfer (k = 0 for the first bit) is the value of `sdi` sampled at edge E0 + k*`CLK_DIV` + `CLK_DIV/2`, which is the edge where `sclk_out` rises. The first bit is the word's most significant bit, and exactly `WORD_W` bits make a word.
- R5: After the last bit, `sclk_out` falls at E0 + `WORD_W`*`CLK_DIV`. One edge later, `sclk_oe` returns to 0 and `sclk_out` returns to 1. While `sclk_oe` is 0, `sclk_out` is 1.
- R6: The completed word goes to `ctrl_reg` when the captured select is 0 and to `cal_reg` when it is 1. The other register is unchanged.
- R7: `addr_sel` is captured at E0. Changes to it during the transfer do not alter the destination.
- R8: `wr_done` is a one-cycle pulse in the cycle after E0 + `WORD_W`*`CLK_DIV` + 1, and the destination register takes its new value at that same edge. Neither register changes at any other time.
- R9: `frame_n` sampled high at any edge after E0, up to and including the edge that samples the last bit, ends the transfer. `sclk_oe` drops after that edge, no `wr_done` pulse follows, and both registers keep their values.
- R10: A completed transfer does not restart while `frame_n` stays low. A new high-to-low transition is needed.
- R11: A strobe fall detected at the edge that completes a word is accepted. The load and the `wr_done` pulse occur, `sclk_oe` stays 1 and a new transfer begins from that edge with a fresh select capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_n | input | 1 | Active-low transfer strobe from the host |
| sdi | input | 1 | Serial data from the host |
| addr_sel | input | 1 | Destination select: 0 control, 1 calibration |
| sclk_out | output | 1 | Generated serial clock, 1 when idle |
| sclk_oe | output | 1 | Output enable for the serial clock pad |
| ctrl_reg | output | WORD_W | Control register contents |
| cal_reg | output | WORD_W | Calibration register contents |
| wr_done | output | 1 | One-cycle pulse on each completed load |

## Verification
Two pairs of events can fall on the same clock edge, and both are provoked on purpose. In the first pair, the strobe is raised exactly at the edge that samples the final bit. The bench then expects an abort: the clock is released and neither register moves. In the second pair, the strobe is pulsed high and low so that its new fall is detected at the edge that loads the finished word. The bench expects the load, the done pulse and an uninterrupted enable in that one cycle, and then a second word delivered to the other register with correct phase timing.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TAIL  = 2'd2,
        ST_FALL  = 2'd3
    } swp_state_e;

    typedef enum logic {
        DEST_CTRL = 1'b0,
        DEST_CAL  = 1'b1
    } swp_dest_e;

    localparam int NUM_DEST = 2;

endpackage

// File: rtl/swp_frame_det.sv
module swp_frame_det (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    output logic fall
);
    typedef struct packed {
        logic prev;
    } fd_s;

    fd_s d, q;

    always_comb begin
        d      = q;
        d.prev = frame_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.prev <= 1'b1;
        else        q      <= d;
    end

    assign fall = q.prev & ~frame_n;
endmodule

// File: rtl/swp_bitclk.sv
module swp_bitclk #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic level,
    output logic rise_next,
    output logic wrap_next
);
    localparam int HALF = CLK_DIV / 2;
    localparam int PH_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } bc_s;

    bc_s d, q;

    always_comb begin
        d = q;
        if (restart)  d.ph = '0;
        else if (run) d.ph = wrap_next ? '0 : q.ph + 1'b1;
        else          d.ph = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.ph <= '0;
        else        q    <= d;
    end

    assign level     = (q.ph >= PH_W'(HALF));
    assign rise_next = (q.ph == PH_W'(HALF - 1));
    assign wrap_next = (q.ph == PH_W'(CLK_DIV - 1));
endmodule

// File: rtl/swp_shreg.sv
module swp_shreg #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              din,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } sh_s;

    sh_s d, q;

    always_comb begin
        d = q;
        if (clear)      d.sr = '0;
        else if (shift) d.sr = {q.sr[WORD_W-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q.sr <= '0;
        else        q    <= d;
    end

    assign word = q.sr;
endmodule

// File: rtl/selfclk_wr_port.sv
module selfclk_wr_port #(
    parameter int               WORD_W    = 24,
    parameter int               CLK_DIV   = 4,
    parameter logic [WORD_W-1:0] CTRL_INIT = '0,
    parameter logic [WORD_W-1:0] CAL_INIT  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              sdi,
    input  logic              addr_sel,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic [WORD_W-1:0] ctrl_reg,
    output logic [WORD_W-1:0] cal_reg,
    output logic              wr_done
);
    import swp_pkg::*;

    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        swp_state_e                         st;
        logic [CNT_W-1:0]                   bits;
        swp_dest_e                          dest;
        logic [NUM_DEST-1:0][WORD_W-1:0]    bank;
        logic                               done;
    } top_s;

    top_s d, q;

    logic              fall;
    logic              level, rise_next, wrap_next;
    logic              start, capture, run;
    logic [WORD_W-1:0] word;

    swp_frame_det u_fdet (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .fall    (fall)
    );

    swp_bitclk #(.CLK_DIV(CLK_DIV)) u_bclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (start),
        .level     (level),
        .rise_next (rise_next),
        .wrap_next (wrap_next)
    );

    swp_shreg #(.WORD_W(WORD_W)) u_shr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .shift (capture),
        .din   (sdi),
        .word  (word)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        start   = 1'b0;
        capture = 1'b0;
        run     = (q.st == ST_SHIFT) || (q.st == ST_TAIL);
        case (q.st)
            ST_IDLE: begin
                if (fall) begin
                    start  = 1'b1;
                    d.st   = ST_SHIFT;
                    d.bits = '0;
                    d.dest = swp_dest_e'(addr_sel);
                end
            end
            ST_SHIFT: begin
                if (frame_n) begin
                    d.st = ST_IDLE;
                end else if (rise_next) begin
                    capture = 1'b1;
                    d.bits  = q.bits + 1'b1;
                    if (q.bits == CNT_W'(WORD_W - 1)) d.st = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (wrap_next) d.st = ST_FALL;
            end
            ST_FALL: begin
                for (int i = 0; i < NUM_DEST; i++) begin
                    if (q.dest == swp_dest_e'(i)) d.bank[i] = word;
                end
                d.done = 1'b1;
                if (fall) begin
                    start  = 1'b1;
                    d.st   = ST_SHIFT;
                    d.bits = '0;
                    d.dest = swp_dest_e'(addr_sel);
                end else begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st                  <= ST_IDLE;
            q.bits                <= '0;
            q.dest                <= DEST_CTRL;
            q.bank[int'(DEST_CTRL)] <= CTRL_INIT;
            q.bank[int'(DEST_CAL)]  <= CAL_INIT;
            q.done                <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sclk_oe  = (q.st != ST_IDLE);
    assign sclk_out = sclk_oe ? level : 1'b1;
    assign ctrl_reg = q.bank[int'(DEST_CTRL)];
    assign cal_reg  = q.bank[int'(DEST_CAL)];
    assign wr_done  = q.done;
endmodule

// File: rtl/swp_wr_checker.sv
module swp_wr_checker #(
    parameter int WORD_W  = 24,
    parameter int CLK_DIV = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              sclk_out,
    input logic              sclk_oe,
    input logic              wr_done,
    input logic [WORD_W-1:0] ctrl_reg,
    input logic [WORD_W-1:0] cal_reg
);
    localparam int HALF = CLK_DIV / 2;

    logic [15:0] run_len_q;
    logic        last_sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len_q   <= 16'd1;
            last_sclk_q <= 1'b1;
        end else begin
            run_len_q   <= (!sclk_oe || sclk_out != last_sclk_q || wr_done) ? 16'd1 : run_len_q + 16'd1;
            last_sclk_q <= sclk_out;
        end
    end

    assert_enable_needs_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_oe) |-> (!$past(frame_n) && $past(frame_n, 2)));

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_oe) |-> !sclk_out);

    assert_phase_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && $past(sclk_oe) && sclk_out != $past(sclk_out)) |-> (run_len_q == 16'(HALF)));

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_oe |-> sclk_out);

    assert_done_after_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> ($past(sclk_oe) && !$past(sclk_out)));

    assert_one_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> ($stable(ctrl_reg) || $stable(cal_reg)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    assert_regs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_done |-> ($stable(ctrl_reg) && $stable(cal_reg)));
endmodule

bind selfclk_wr_port swp_wr_checker #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .sclk_out (sclk_out),
    .sclk_oe  (sclk_oe),
    .wr_done  (wr_done),
    .ctrl_reg (ctrl_reg),
    .cal_reg  (cal_reg)
);

// File: tb/sim_selfclk_wr_port.sv
module sim_selfclk_wr_port;
    localparam int W    = 24;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int NV   = 6;
    // entry: {flip select during transfer, select, word}
    localparam logic [W+1:0] VEC [NV] = '{
        {1'b0, 1'b0, 24'hA5C3F0},
        {1'b0, 1'b1, 24'h123456},
        {1'b1, 1'b0, 24'hFFFFFF},
        {1'b0, 1'b1, 24'h000001},
        {1'b1, 1'b1, 24'h800000},
        {1'b0, 1'b0, 24'h5A5A5A}
    };

    logic clk = 1'b0;
    logic rst_n, frame_n, sdi, addr_sel;
    logic sclk_out, sclk_oe, wr_done;
    logic [W-1:0] ctrl_reg, cal_reg;
    logic [W-1:0] exp_ctrl = '0, exp_cal = '0;
    int n_checks = 0, n_fail = 0;

    always #4 clk = ~clk;

    selfclk_wr_port #(.WORD_W(W), .CLK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sdi(sdi), .addr_sel(addr_sel),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .ctrl_reg(ctrl_reg), .cal_reg(cal_reg),
        .wr_done(wr_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drives one transfer and checks every cycle of it. abort_c >= 0 raises the
    // strobe for edge E0+abort_c. pre: E0 already happened. chain: re-strobe so
    // the next fall lands on the loading edge.
    task automatic run_frame(input logic [W-1:0] w, input logic a, input logic flip,
                             input int abort_c, input bit pre, input bit chain,
                             input logic next_a);
        int last = W * DIV;
        int c_start = pre ? 1 : 0;
        int e_sclk = 0, e_oe = 0, e_done = 0, e_hold = 0, e_start = 0;
        logic [W-1:0] c0 = exp_ctrl;
        logic [W-1:0] c1 = exp_cal;
        bit fin = 0;
        if (!pre) @(negedge clk);
        for (int c = c_start; !fin; c++) begin
            if (c != c_start) begin
                int j;
                logic es;
                j = c - 1;
                @(negedge clk);
                if (abort_c >= 0 && j == abort_c) begin
                    if (sclk_oe !== 1'b0 || sclk_out !== 1'b1) e_oe++;
                    if (wr_done !== 1'b0) e_done++;
                    if (ctrl_reg !== c0 || cal_reg !== c1) e_hold++;
                    fin = 1;
                end else if (j <= last) begin
                    es = (j < last) ? ((j % DIV) >= HALF) : 1'b0;
                    if (j == 0 && (sclk_oe !== 1'b1 || sclk_out !== 1'b0)) e_start++;
                    if (sclk_oe !== 1'b1) e_oe++;
                    if (sclk_out !== es) e_sclk++;
                    if (wr_done !== 1'b0) e_done++;
                    if (ctrl_reg !== c0 || cal_reg !== c1) e_hold++;
                end else if (j == last + 1) begin
                    if (wr_done !== 1'b1) e_done++;
                    if (sclk_oe !== chain) e_oe++;
                    if (sclk_out !== !chain) e_sclk++;
                    if (a == 1'b0) exp_ctrl = w; else exp_cal = w;
                    check(ctrl_reg === exp_ctrl, flip ? "R4 R6 R7" : "R4 R6", "ctrl_reg", ctrl_reg, exp_ctrl);
                    check(cal_reg === exp_cal, flip ? "R4 R6 R7" : "R4 R6", "cal_reg", cal_reg, exp_cal);
                    if (chain) fin = 1;
                end else begin
                    if (wr_done !== 1'b0) e_done++;
                    if (sclk_oe !== 1'b0) e_oe++;
                    fin = 1;
                end
            end
            if (!fin) begin
                int bi;
                bi = W - 1 - c / DIV;
                sdi = (bi >= 0) ? w[bi] : 1'b0;
                addr_sel = (flip && c > 0) ? ~a : a;
                if (abort_c >= 0 && c >= abort_c)   frame_n = 1'b1;
                else if (chain && c == last)        frame_n = 1'b1;
                else if (chain && c == last + 1) begin
                    frame_n  = 1'b0;
                    addr_sel = next_a;
                end else                            frame_n = 1'b0;
                @(posedge clk);
            end
        end
        if (!pre) check(e_start == 0, "R2", "enable/low at start", e_start, 0);
        check(e_sclk == 0, "R3", "sclk phase mismatches", e_sclk, 0);
        check(e_oe == 0, "R5", "enable mismatches", e_oe, 0);
        check(e_done == 0, "R8", "done mismatches", e_done, 0);
        check(e_hold == 0, (abort_c >= 0) ? "R9" : "R8", "register changes", e_hold, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int bad;
        rst_n = 1'b0; frame_n = 1'b1; sdi = 1'b0; addr_sel = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sclk_oe === 1'b0 && sclk_out === 1'b1 && wr_done === 1'b0, "R1", "idle outputs in reset",
              {sclk_oe, sclk_out, wr_done}, 3'b010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ctrl_reg === '0 && cal_reg === '0, "R1", "registers after reset", ctrl_reg | cal_reg, 0);
        check(sclk_oe === 1'b0 && sclk_out === 1'b1, "R1", "idle after reset", {sclk_oe, sclk_out}, 2'b01);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i][W-1:0], VEC[i][W], VEC[i][W+1], -1, 1'b0, 1'b0, 1'b0);
            frame_n = 1'b1;
            repeat (2) @(negedge clk);
        end

        // R9: early abort and abort on the edge that samples the last bit
        run_frame(24'hDEAD01, 1'b0, 1'b0, 5, 1'b0, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        run_frame(24'hBEEF02, 1'b1, 1'b0, (W - 1) * DIV + HALF, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check(ctrl_reg === exp_ctrl && cal_reg === exp_cal, "R9", "registers after aborts",
              ctrl_reg ^ cal_reg, exp_ctrl ^ exp_cal);

        // R10: strobe held low after completion
        run_frame(24'h0F0F0F, 1'b1, 1'b0, -1, 1'b0, 1'b0, 1'b0);
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (sclk_oe !== 1'b0 || wr_done !== 1'b0) bad++;
        end
        check(bad == 0, "R10", "restart while strobe held low", bad, 0);
        frame_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: new fall on the loading edge, then a second word to the other register
        run_frame(24'h3C3C3C, 1'b0, 1'b0, -1, 1'b0, 1'b1, 1'b1);
        check(sclk_oe === 1'b1 && wr_done === 1'b1, "R11", "load and restart together",
              {sclk_oe, wr_done}, 2'b11);
        run_frame(24'hC30FA5, 1'b1, 1'b0, -1, 1'b1, 1'b0, 1'b0);
        check(ctrl_reg === 24'h3C3C3C && cal_reg === 24'hC30FA5, "R11", "chained words",
              {ctrl_reg[7:0], cal_reg[7:0]}, 16'h3CA5);
        frame_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule